// File: doc/BRIEF.md
# Output Voltage Reference Slew Controller

This block produces the 7-bit reference code for the output-voltage DAC of a step-down regulator. The voltage that a code stands for is 0.600 V plus the code times 6.25 mV, so codes 0 to 127 span 0.600 V to 1.39375 V, and code 80 means 1.100 V. Two setpoint registers each hold an enable bit and a target code. A select pin picks which register is live. The same pin also picks which of two mode bits decides between forced PWM and automatic PFM/PWM operation.

A move to a higher code is paced. The code climbs one step at a time, and the spacing between steps is set by a 3-bit rate field. The rates run from 64 mV/µs, halving each time, down to 0.5 mV/µs. The spacing is computed from the clock frequency when the design is elaborated. A move to a lower code lands on the target at once. A hold output then stops the modulator from switching until an external comparator reports that the output has come down to the new level. Status outputs show whether a rising or a falling move is still in progress.

Top module: `vref_slew_ctrl`

## Requirements
- R1: The selected target is `setpt0_reg[6:0]` when `sel_pin` is 0 and `setpt1_reg[6:0]` when `sel_pin` is 1. After every move has finished, `dac_code` equals the selected target.
- R2: `reg_on` is 1 only when `en_pin` is 1 and bit 7 of the selected setpoint register is 1. Otherwise it is 0.
- R3: `force_pwm` equals `mode_sel[0]` when `sel_pin` is 0 and `mode_sel[1]` when `sel_pin` is 1. A value of 1 means forced PWM and 0 means automatic PFM/PWM.
- R4: While the selected target is above `dac_code`, the code rises by exactly 1 per step. Consecutive steps are round(CLK_KHZ·2^k/10240) clock cycles apart, where k is `rate_sel`. At 50 MHz this gives 5, 10, 20, 39, 78, 156, 313 and 625 cycles for k = 0 to 7.
- R5: `pos_flag` is 1 exactly when the selected target is above `dac_code`.
- R6: When the selected target is below `dac_code`, the code equals the target on the next clock edge. On that same edge `neg_flag` and `sw_hold` go to 1.
- R7: `neg_flag` and `sw_hold` stay at 1 until a clock edge at which `out_reached` is 1 and the target equals the code. A new downward move on the same edge keeps them at 1.
- R8: If the target changes during a rising ramp, the code continues from its present value. It never changes by more than +1 per cycle, and it ends at the new target. A new target below the present code follows R6.
- R9: While `rst_n` is 0, `dac_code` is RESET_CODE (default 0), and `neg_flag` and `sw_hold` are 0.
- R10: A target above the code while a falling move is waiting clears `neg_flag` and `sw_hold` on the next edge, and a ramp starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_KHZ kHz |
| rst_n | input | 1 | Active-low reset |
| en_pin | input | 1 | Hardware enable |
| sel_pin | input | 1 | Selects setpoint register 0 or 1 |
| setpt0_reg | input | 8 | Bit 7: enable, bits 6:0: target code, used when select is low |
| setpt1_reg | input | 8 | Bit 7: enable, bits 6:0: target code, used when select is high |
| rate_sel | input | 3 | Rising slew rate, 0 = 64 mV/µs down to 7 = 0.5 mV/µs |
| mode_sel | input | 2 | Forced-PWM bits; bit 0 applies when select is low, bit 1 when select is high |
| out_reached | input | 1 | Comparator: the output has reached the target |
| dac_code | output | 7 | Reference code to the DAC |
| reg_on | output | 1 | The regulator is enabled |
| force_pwm | output | 1 | 1 = forced PWM, 0 = automatic PFM/PWM |
| pos_flag | output | 1 | A rising move is in progress |
| neg_flag | output | 1 | A falling move is waiting for the output |
| sw_hold | output | 1 | Suppress switching |

## Verification
Two events can land on the same clock edge, and both are provoked on purpose.

The first is a pacer step arriving on the edge where the target is dropped below the climbing code. The bench cuts a fast ramp short at several cycle offsets so that some drops meet a step. It then requires the code to land exactly on the new, lower target with the hold raised. The fall must win over the increment.

The second is the comparator reporting arrival on the same edge as a fresh downward move. The bench requires the hold to stay set in that case.

Random register and pin patterns are also judged cycle by cycle against the select, enable, mode and flag rules.

// File: rtl/vref_pkg.sv
package vref_pkg;
  localparam int RATE_W_DEF = 3;
  localparam int CODE_W_DEF = 7;

  // cycles per code step: 6.25 mV at 64/2^k mV/us, rounded, at least 1
  function automatic int step_cycles(input int clk_khz, input int k);
    int c;
    c = (clk_khz * (1 << k) + 5120) / 10240;
    if (c < 1) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/vref_select.sv
module vref_select #(
  parameter int CODE_W = 7
) (
  input  logic              en_pin,
  input  logic              sel_pin,
  input  logic [CODE_W:0]   setpt0_reg,
  input  logic [CODE_W:0]   setpt1_reg,
  input  logic [1:0]        mode_sel,
  output logic [CODE_W-1:0] tgt,
  output logic              on,
  output logic              fpwm
);
  logic [CODE_W:0] live;

  always_comb begin
    live = sel_pin ? setpt1_reg : setpt0_reg;
    tgt  = live[CODE_W-1:0];
    on   = en_pin & live[CODE_W];
    fpwm = sel_pin ? mode_sel[1] : mode_sel[0];
  end
endmodule

// File: rtl/vref_pacer.sv
module vref_pacer
  import vref_pkg::*;
#(
  parameter int CLK_KHZ = 50000,
  parameter int RATE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              step
);
  localparam int NR    = 1 << RATE_W;
  localparam int MAXC  = step_cycles(CLK_KHZ, NR - 1);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] lim_tbl [NR];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;

  generate
    for (genvar g = 0; g < NR; g++) begin : g_tbl
      assign lim_tbl[g] = CNT_W'(step_cycles(CLK_KHZ, g) - 1);
    end
  endgenerate

  assign lim  = lim_tbl[rate];
  assign step = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || step) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vref_tracker.sv
module vref_tracker #(
  parameter int CODE_W     = 7,
  parameter int RESET_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt,
  input  logic              step,
  input  logic              reached,
  output logic [CODE_W-1:0] code,
  output logic              neg,
  output logic              rise_pend
);
  assign rise_pend = tgt > code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= CODE_W'(RESET_CODE);
      neg  <= 1'b0;
    end else if (tgt < code) begin
      code <= tgt;
      neg  <= 1'b1;
    end else if (tgt > code) begin
      neg <= 1'b0;
      if (step) code <= code + 1'b1;
    end else if (reached) begin
      neg <= 1'b0;
    end
  end

  // R4
  inc_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code > $past(code)) |-> (code == $past(code) + 1'b1));

  // R6
  fall_sets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt < code) |=> (neg && code == $past(tgt)));

  // R8
  code_move_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> ($past(step) || ($past(tgt) < $past(code))));
endmodule

// File: rtl/vref_slew_ctrl.sv
module vref_slew_ctrl
  import vref_pkg::*;
#(
  parameter int CLK_KHZ    = 50000,
  parameter int CODE_W     = CODE_W_DEF,
  parameter int RATE_W     = RATE_W_DEF,
  parameter int RESET_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic              sel_pin,
  input  logic [CODE_W:0]   setpt0_reg,
  input  logic [CODE_W:0]   setpt1_reg,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [1:0]        mode_sel,
  input  logic              out_reached,
  output logic [CODE_W-1:0] dac_code,
  output logic              reg_on,
  output logic              force_pwm,
  output logic              pos_flag,
  output logic              neg_flag,
  output logic              sw_hold
);
  logic [CODE_W-1:0] tgt;
  logic              step;
  logic              rise_pend;

  vref_select #(.CODE_W(CODE_W)) u_sel (
    .en_pin(en_pin), .sel_pin(sel_pin), .setpt0_reg(setpt0_reg),
    .setpt1_reg(setpt1_reg), .mode_sel(mode_sel), .tgt(tgt),
    .on(reg_on), .fpwm(force_pwm)
  );

  vref_pacer #(.CLK_KHZ(CLK_KHZ), .RATE_W(RATE_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .run(rise_pend), .rate(rate_sel), .step(step)
  );

  vref_tracker #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_trk (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .step(step), .reached(out_reached),
    .code(dac_code), .neg(neg_flag), .rise_pend(rise_pend)
  );

  assign pos_flag = rise_pend;
  assign sw_hold  = neg_flag;

  // R7
  hold_from_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_hold) |-> (dac_code < $past(dac_code)));
endmodule

// File: tb/vref_slew_ctrl_test.sv
`timescale 1ns/1ps
module vref_slew_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_pin, sel_pin, out_reached;
  logic [7:0] setpt0_reg, setpt1_reg;
  logic [2:0] rate_sel;
  logic [1:0] mode_sel;
  logic [6:0] dac_code;
  logic       reg_on, force_pwm, pos_flag, neg_flag, sw_hold;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  vref_slew_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .sel_pin(sel_pin),
    .setpt0_reg(setpt0_reg), .setpt1_reg(setpt1_reg), .rate_sel(rate_sel),
    .mode_sel(mode_sel), .out_reached(out_reached), .dac_code(dac_code),
    .reg_on(reg_on), .force_pwm(force_pwm), .pos_flag(pos_flag),
    .neg_flag(neg_flag), .sw_hold(sw_hold)
  );

  always #10 clk = ~clk;

  function automatic int exp_interval(input int k);
    int c;
    c = (50000 * (1 << k) + 5120) / 10240;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int exp_tgt();
    return sel_pin ? int'(setpt1_reg[6:0]) : int'(setpt0_reg[6:0]);
  endfunction

  function automatic int exp_on();
    return (en_pin && (sel_pin ? setpt1_reg[7] : setpt0_reg[7])) ? 1 : 0;
  endfunction

  function automatic int exp_fpwm();
    return (sel_pin ? mode_sel[1] : mode_sel[0]) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    sel_pin     = 1'b0;
    setpt0_reg  = {1'b1, dac_code};
    out_reached = 1'b1;
    tick();
    out_reached = 1'b0;
  endtask

  // R4 spacing and unit steps, R1 end value, R5 flag
  task automatic ramp_check(input int k, input int steps);
    int prev, since, nchg, ncyc, tgtv;
    rate_sel   = 3'(k);
    sel_pin    = 1'b0;
    tgtv       = int'(dac_code) + steps;
    setpt0_reg = {1'b1, 7'(tgtv)};
    #1;
    chk("R5 pos flag at ramp start", int'(pos_flag), 1);
    prev = int'(dac_code); since = 0; nchg = 0; ncyc = 0;
    while (nchg < steps && ncyc < 20000) begin
      tick();
      ncyc++; since++;
      if (int'(dac_code) != prev) begin
        chk("R4 step size", int'(dac_code) - prev, 1);
        if (nchg > 0) chk("R4 step interval", since, exp_interval(k));
        since = 0; nchg++; prev = int'(dac_code);
      end
    end
    chk("R1 ramp end code", int'(dac_code), tgtv);
    chk("R5 pos flag after ramp", int'(pos_flag), 0);
  endtask

  // R6 fall, R7 hold until reached
  task automatic fall_check(input int drop);
    int tgtv;
    sel_pin    = 1'b0;
    tgtv       = int'(dac_code) - drop;
    setpt0_reg = {1'b1, 7'(tgtv)};
    tick();
    chk("R6 code lands on target", int'(dac_code), tgtv);
    chk("R6 neg flag set", int'(neg_flag), 1);
    chk("R6 hold set", int'(sw_hold), 1);
    repeat (3) tick();
    chk("R7 hold kept without comparator", int'(sw_hold), 1);
    out_reached = 1'b1;
    tick();
    out_reached = 1'b0;
    chk("R7 hold cleared by comparator", int'(sw_hold), 0);
    chk("R7 neg flag cleared", int'(neg_flag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c, ok, prev, n;
    void'($urandom(32'd7319));
    rst_n = 1'b0; en_pin = 1'b0; sel_pin = 1'b0; out_reached = 1'b0;
    setpt0_reg = 8'h00; setpt1_reg = 8'h00; rate_sel = 3'd0; mode_sel = 2'b00;
    repeat (3) tick();
    chk("R9 reset code", int'(dac_code), 0);
    chk("R9 reset neg flag", int'(neg_flag), 0);
    chk("R9 reset hold", int'(sw_hold), 0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R5 random pin/register patterns
    for (int i = 0; i < 40; i++) begin
      en_pin     = 1'($urandom);
      sel_pin    = 1'($urandom);
      mode_sel   = 2'($urandom);
      setpt0_reg = 8'($urandom);
      setpt1_reg = 8'($urandom);
      #1;
      chk("R2 enable", int'(reg_on), exp_on());
      chk("R3 mode", int'(force_pwm), exp_fpwm());
      chk("R5 pos flag", int'(pos_flag), (exp_tgt() > int'(dac_code)) ? 1 : 0);
      repeat (1 + $urandom % 4) tick();
    end
    en_pin = 1'b1;
    setpt0_reg = 8'h80;
    tick();
    settle();
    chk("R1 settled at zero", int'(dac_code), 0);

    // R4 directed and random rates
    ramp_check(0, 4);
    ramp_check(1, 3);
    ramp_check(2, 3);
    ramp_check(3, 2);
    for (int i = 0; i < 6; i++) ramp_check(int'($urandom % 6), 2 + int'($urandom % 3));
    ramp_check(6, 2);
    ramp_check(7, 2);

    // R6 R7 falls
    fall_check(5);
    for (int i = 0; i < 4; i++) begin
      ramp_check(0, 3);
      fall_check(1 + int'($urandom % 3));
    end

    // R1 select pin swaps register, downward
    ramp_check(0, 4);
    setpt1_reg = {1'b1, dac_code - 7'd3};
    c = int'(dac_code) - 3;
    sel_pin = 1'b1;
    tick();
    chk("R1 select high picks register 1", int'(dac_code), c);
    chk("R3 mode with select high", int'(force_pwm), exp_fpwm());
    settle();
    chk("R1 select low picks register 0", int'(dac_code), c);

    // R8 retarget upward mid-ramp
    rate_sel = 3'd0;
    c = int'(dac_code);
    setpt0_reg = {1'b1, 7'(c + 10)};
    n = 0; prev = c;
    while (n < 2) begin
      tick();
      if (int'(dac_code) != prev) begin n++; prev = int'(dac_code); end
    end
    setpt0_reg = {1'b1, dac_code + 7'd2};
    c = int'(dac_code) + 2;
    ok = 1; prev = int'(dac_code);
    repeat (60) begin
      tick();
      if (int'(dac_code) - prev > 1 || int'(dac_code) < prev) ok = 0;
      prev = int'(dac_code);
    end
    chk("R8 no jump after retarget", ok, 1);
    chk("R8 ends at new target", int'(dac_code), c);

    // R8 retarget downward mid-ramp, R6 fall beats a step (several offsets)
    for (int off = 0; off < 5; off++) begin
      c = int'(dac_code);
      setpt0_reg = {1'b1, 7'(c + 6)};
      repeat (6 + off) tick();
      setpt0_reg = {1'b1, 7'(c)};
      tick();
      chk("R8 downward retarget lands", int'(dac_code), c);
      chk("R6 hold after cut ramp", int'(sw_hold), 1);
      settle();
    end

    // R7 comparator on same edge as a new fall
    ramp_check(0, 3);
    c = int'(dac_code) - 2;
    setpt0_reg = {1'b1, 7'(c)};
    out_reached = 1'b1;
    tick();
    out_reached = 1'b0;
    chk("R7 new fall keeps hold", int'(sw_hold), 1);
    chk("R6 code on same-edge fall", int'(dac_code), c);

    // R10 rise during fall wait
    setpt0_reg = {1'b1, 7'(c + 2)};
    tick();
    chk("R10 neg flag cleared by rise", int'(neg_flag), 0);
    chk("R10 pos flag set", int'(pos_flag), 1);
    repeat (20) tick();
    chk("R10 ramp completes", int'(dac_code), c + 2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule